// File: doc/BRIEF.md
# Converter Power-Down Controller

This block sequences the low-power states of a multichannel audio converter: one ADC path and four stereo DAC pairs. Software writes a single control word over a plain write port. The word holds three kinds of setting: a device-wide power-down bit, an ADC disable bit and one disable bit per DAC pair. The controller turns these settings into a registered enable for each path. It also issues a one-cycle reset to a path's digital filter each time that path enters or leaves its disabled state. For each DAC pair it drives a midscale select and replaces that pair's sample data with the midscale code.

The settings are applied only at a sample strobe, so no path changes state partway through a sample. A pending write waits in a holding register until the next strobe. The device-wide bit overrides every other setting, and after reset every path starts out disabled.

DAC sample frames pass through a single-register stream stage with valid/ready handshakes. A frame carries eight channels, and channel c belongs to pair c/2. The stage accepts a frame whenever its output register is empty or is being drained in the same cycle. While the output is valid and not yet taken, the stage stalls the input and holds the output frame unchanged. Each channel of a disabled pair leaves the stage as all zeros, which is the two's-complement midscale code.

Top module: `cnv_pwr_ctrl`

## Requirements
- R1: After reset, adc_en is 0, dac_en is 0000, dac_mid_sel is 1111, and both filter-reset outputs are 0.
- R2: A write reaches the paths only at the first sample strobe after the write cycle. The outputs change in the cycle that follows the clock edge at which smp_stb is high. Before that strobe they hold their old values.
- R3: The control word is written at address REG_ADDR. Bit 4 is the ADC disable, and adc_en equals the inverse of (bit 4 OR bit 7) as committed.
- R4: Bits 3:0 of the control word disable DAC pairs 0 to 3, one bit per pair. For each pair p, dac_en[p] is the inverse of (bit p OR bit 7), and dac_mid_sel[p] is the inverse of dac_en[p].
- R5: Bit 7 is the device power-down. When it is committed as 1, adc_en is 0 and dac_en is 0000, whatever bits 4 and 3:0 hold.
- R6: A path's filter-reset output is high for exactly one clock cycle after a strobe that changes that path's effective disable, in either direction. It stays low after a strobe that leaves the disable unchanged.
- R7: When a frame is accepted, each channel of a pair whose dac_mid_sel is 1 is output as 0. Each channel of an enabled pair is output unchanged.
- R8: in_ready equals (not out_valid) or out_ready. While out_valid is high and out_ready is low, out_valid stays high and out_data stays stable.
- R9: A write to any address other than REG_ADDR has no effect on the controller state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | One-cycle sample strobe; commits the pending settings |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | AW | Register write address |
| wr_data | input | 8 | Register write data (control word) |
| adc_en | output | 1 | ADC path enable |
| adc_flt_rst | output | 1 | ADC filter reset pulse |
| dac_en | output | 4 | Per-pair DAC enable |
| dac_flt_rst | output | 4 | Per-pair DAC filter reset pulse |
| dac_mid_sel | output | 4 | Per-pair midscale output select |
| in_valid | input | 1 | Input DAC frame valid |
| in_ready | output | 1 | Input DAC frame ready |
| in_data | input | 8*SW | Eight input channels, channel c at bits c*SW upward |
| out_valid | output | 1 | Output DAC frame valid |
| out_ready | input | 1 | Output DAC frame ready |
| out_data | output | 8*SW | Eight output channels with disabled pairs forced to zero |

## Verification
The bench writes new settings and then checks the outputs before and after a strobe. A design that commits writes immediately would show the change one strobe early. It also issues a strobe with no setting change and checks that no filter reset appears, which catches a design that pulses on every strobe. Separate tests check that the reset pulse fires on both the disable and the enable edge, and that the device-wide bit overrides pairs that are otherwise enabled. The stream checks stall the output with a second frame waiting and confirm the stage does not overwrite the held frame. Frames are sent with a mix of disabled and enabled pairs to catch a pair-to-channel mapping that is off by one. A write to a stray address is checked to confirm it leaves the enables unchanged.

// File: rtl/cnv_pwr_pkg.sv
package cnv_pwr_pkg;
  localparam int PAIRS    = 4;
  localparam int CHANS    = 2 * PAIRS;
  localparam int PATHS    = PAIRS + 1;
  localparam int DOWN_BIT = 7;
  localparam int ADC_BIT  = 4;
  localparam int PAIR_LSB = 0;

  typedef struct packed {
    logic             down;
    logic             adc_off;
    logic [PAIRS-1:0] pair_off;
  } pwr_cfg_t;

  function automatic pwr_cfg_t cfg_reset();
    pwr_cfg_t c;
    c.down     = 1'b0;
    c.adc_off  = 1'b1;
    c.pair_off = '1;
    return c;
  endfunction

  function automatic pwr_cfg_t cfg_decode(input logic [7:0] w);
    pwr_cfg_t c;
    c.down     = w[DOWN_BIT];
    c.adc_off  = w[ADC_BIT];
    c.pair_off = w[PAIR_LSB +: PAIRS];
    return c;
  endfunction
endpackage

// File: rtl/cnv_pwr_regs.sv
module cnv_pwr_regs
  import cnv_pwr_pkg::*;
#(
  parameter int AW = 5,
  parameter logic [AW-1:0] REG_ADDR = 5'h0C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  output pwr_cfg_t      cfg
);
  logic hit;
  assign hit = wr_en && (wr_addr == REG_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n)   cfg <= cfg_reset();
    else if (hit) cfg <= cfg_decode(wr_data);
  end

  // R9: a stray write leaves the holding register alone
  p_stray_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != REG_ADDR) |=> $stable(cfg));
endmodule

// File: rtl/cnv_pwr_path.sv
module cnv_pwr_path (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_stb,
  input  logic dis_want,
  output logic dis_q,
  output logic flt_rst
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dis_q   <= 1'b1;
      flt_rst <= 1'b0;
    end else begin
      flt_rst <= 1'b0;
      if (smp_stb) begin
        dis_q   <= dis_want;
        flt_rst <= (dis_want != dis_q);
      end
    end
  end

  // R2: state moves only on a strobe
  p_change_on_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_q != $past(dis_q)) |-> $past(smp_stb));
  // R6: a reset pulse accompanies every state change
  p_pulse_on_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dis_q != $past(dis_q)) |-> flt_rst);
endmodule

// File: rtl/cnv_pwr_mute.sv
module cnv_pwr_mute
  import cnv_pwr_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PAIRS-1:0]    mute,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [CHANS*SW-1:0] in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [CHANS*SW-1:0] out_data
);
  logic                take;
  logic [CHANS*SW-1:0] shaped;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  for (genvar c = 0; c < CHANS; c++) begin : g_ch
    assign shaped[c*SW +: SW] = mute[c/2] ? '0 : in_data[c*SW +: SW];

    // R7: a muted pair leaves the stage at midscale
    p_mid_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (take && mute[c/2]) |=> (out_data[c*SW +: SW] == '0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= shaped;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R8: a stalled frame is held
  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/cnv_pwr_ctrl.sv
module cnv_pwr_ctrl
  import cnv_pwr_pkg::*;
#(
  parameter int SW = 16,
  parameter int AW = 5,
  parameter logic [AW-1:0] REG_ADDR = 5'h0C
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_stb,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_addr,
  input  logic [7:0]          wr_data,
  output logic                adc_en,
  output logic                adc_flt_rst,
  output logic [PAIRS-1:0]    dac_en,
  output logic [PAIRS-1:0]    dac_flt_rst,
  output logic [PAIRS-1:0]    dac_mid_sel,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [CHANS*SW-1:0] in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [CHANS*SW-1:0] out_data
);
  pwr_cfg_t         cfg;
  logic [PATHS-1:0] want, dis, rst;

  cnv_pwr_regs #(.AW(AW), .REG_ADDR(REG_ADDR)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg(cfg)
  );

  // path 0 is the ADC, path 1+p is DAC pair p
  assign want[0] = cfg.down | cfg.adc_off;
  for (genvar p = 0; p < PAIRS; p++) begin : g_want
    assign want[p+1] = cfg.down | cfg.pair_off[p];
  end

  for (genvar i = 0; i < PATHS; i++) begin : g_path
    cnv_pwr_path path_i (
      .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb),
      .dis_want(want[i]), .dis_q(dis[i]), .flt_rst(rst[i])
    );
  end

  assign adc_en      = !dis[0];
  assign adc_flt_rst = rst[0];
  assign dac_en      = ~dis[PATHS-1:1];
  assign dac_mid_sel = dis[PATHS-1:1];
  assign dac_flt_rst = rst[PATHS-1:1];

  cnv_pwr_mute #(.SW(SW)) mute_i (
    .clk(clk), .rst_n(rst_n), .mute(dac_mid_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // R5: device power-down overrides every path
  p_down_override_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && cfg.down) |=> (!adc_en && dac_en == '0));
  // R3: a committed clear ADC setting enables the ADC
  p_adc_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && !cfg.down && !cfg.adc_off) |=> adc_en);
  // R4: a committed pair-off bit disables that pair
  p_pair_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> ((dac_en & $past(cfg.pair_off)) == '0));
endmodule

// File: tb/cnv_pwr_ctrl_tb_top.sv
module cnv_pwr_ctrl_tb_top;
  localparam int SW = 16;
  localparam int AW = 5;
  localparam logic [AW-1:0] RA = 5'h0C;
  localparam int NC = 8;

  logic clk = 1'b0, rst_n = 1'b0, smp_stb = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic adc_en, adc_flt_rst, in_ready, out_valid;
  logic [3:0] dac_en, dac_flt_rst, dac_mid_sel;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [NC*SW-1:0] in_data = '0, out_data;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cnv_pwr_ctrl #(.SW(SW), .AW(AW), .REG_ADDR(RA)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .adc_en(adc_en),
    .adc_flt_rst(adc_flt_rst), .dac_en(dac_en), .dac_flt_rst(dac_flt_rst),
    .dac_mid_sel(dac_mid_sel), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // enables packed {adc, dac[3:0]}, mid sel, resets {adc, dac}
  task automatic chk_state(input string tag, input logic a, input logic [3:0] d,
                           input logic ar, input logic [3:0] dr);
    chk({tag, " en"}, {27'd0, adc_en, dac_en}, {27'd0, a, d});
    chk({tag, " mid"}, {28'd0, dac_mid_sel}, {28'd0, ~d});
    chk({tag, " rst"}, {27'd0, adc_flt_rst, dac_flt_rst}, {27'd0, ar, dr});
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic stb();
    @(negedge clk); smp_stb = 1'b1;
    @(negedge clk); smp_stb = 1'b0;
  endtask

  function automatic logic [NC*SW-1:0] mk_frame(input logic [15:0] base);
    logic [NC*SW-1:0] f;
    for (int c = 0; c < NC; c++) f[c*SW +: SW] = base + 16'(c) * 16'h0111;
    return f;
  endfunction

  task automatic chk_frame(input string tag, input logic [NC*SW-1:0] f, input logic [3:0] off);
    for (int c = 0; c < NC; c++)
      chk(tag, {16'd0, out_data[c*SW +: SW]}, {16'd0, off[c/2] ? 16'd0 : f[c*SW +: SW]});
  endtask

  task automatic t_reset();
    chk_state("R1 reset", 1'b0, 4'b0000, 1'b0, 4'b0000);
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
    stb();
    chk_state("R6 no change no pulse", 1'b0, 4'b0000, 1'b0, 4'b0000);
  endtask

  task automatic t_commit();
    wr(RA, 8'h00);
    @(negedge clk);
    chk_state("R2 before strobe", 1'b0, 4'b0000, 1'b0, 4'b0000);
    stb();
    chk_state("R2 R3 R4 enable all", 1'b1, 4'b1111, 1'b1, 4'b1111);
    @(negedge clk);
    chk_state("R6 pulse one cycle", 1'b1, 4'b1111, 1'b0, 4'b0000);
  endtask

  task automatic t_pairs();
    wr(RA, 8'h05);
    stb();
    chk_state("R4 R6 pairs 0 2 off", 1'b1, 4'b1010, 1'b0, 4'b0101);
    wr(RA, 8'h15);
    stb();
    chk_state("R3 R6 adc off", 1'b0, 4'b1010, 1'b1, 4'b0000);
  endtask

  task automatic t_stray();
    wr(5'h0D, 8'h00);
    wr(5'h00, 8'h00);
    stb();
    chk_state("R9 stray write ignored", 1'b0, 4'b1010, 1'b0, 4'b0000);
  endtask

  task automatic t_data();
    logic [NC*SW-1:0] f;
    f = mk_frame(16'h1234);
    out_ready = 1'b1;
    @(negedge clk); in_valid = 1'b1; in_data = f;
    @(negedge clk); in_valid = 1'b0;
    chk("R7 out_valid", {31'd0, out_valid}, 32'd1);
    chk_frame("R7 pairs 0 2 forced midscale", f, 4'b0101);
    @(negedge clk);
    chk("R8 drained", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_stall();
    logic [NC*SW-1:0] fa, fb;
    wr(RA, 8'h08);
    stb();
    chk_state("R4 only pair 3 off", 1'b1, 4'b0111, 1'b1, 4'b1101);
    fa = mk_frame(16'h0A01);
    fb = mk_frame(16'h5B02);
    out_ready = 1'b0;
    @(negedge clk); in_valid = 1'b1; in_data = fa;
    @(negedge clk); in_data = fb;
    chk("R8 stalled in_ready", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    chk("R8 held valid", {31'd0, out_valid}, 32'd1);
    chk_frame("R8 held frame", fa, 4'b1000);
    chk("R8 ready follows out_ready", {31'd0, in_ready}, 32'd0);
    out_ready = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    chk_frame("R7 R8 next frame", fb, 4'b1000);
    @(negedge clk);
  endtask

  task automatic t_down();
    wr(RA, 8'h80);
    stb();
    chk_state("R5 down override", 1'b0, 4'b0000, 1'b1, 4'b0111);
    wr(RA, 8'h00);
    stb();
    chk_state("R5 R6 leave down", 1'b1, 4'b1111, 1'b1, 4'b1111);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_commit();
    t_pairs();
    t_stray();
    t_data();
    t_stall();
    t_down();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule